// File: doc/BRIEF.md
# Automatic Transmit/Receive GPIO Controller

This block drives a 32-pin general-purpose I/O bank toward two radio front-end boards. Software loads a direction mask and four pin-value patterns once. After that, the value driven on the output pins is chosen by hardware from the live activity of the radio. The receive-running and transmit-running flags select one of four activity states, and the pattern for that state appears on every pin marked as an output. An analog transmit/receive antenna switch wired to one of these pins therefore toggles on the clock that enables the transmit chain, and software never writes the pins directly.

The pins form two 16-bit groups. Bits 15:0 belong to the receive-side board and bits 31:16 to the transmit-side board. Each pin has its own output-enable, so a pin marked as an input is left undriven. Its level passes through a two-flop synchronizer and can be read back over the configuration bus.

The state machine has four states: `MODE_IDLE`, `MODE_RX`, `MODE_TX` and `MODE_DUPLEX`. Its transitions are named after the state they enter: enter-idle ({tx,rx} = 00), enter-rx (01), enter-tx (10) and enter-duplex (11). Every state can reach every state, and any state can reach itself, on every clock. The state register is the only stage between the activity flags and the pins.

Top module: `atr_gpio_ctrl`

## Requirements
- R1: During and after reset, every output-enable is 0 and every output pin is 0. The direction register, the four pattern registers and the synchronized input readback all read 0.
- R2: A write (`cfg_wr`=1 at a rising edge) stores `cfg_wdata` at the addressed register, and `cfg_rdata` returns it combinationally for the address presented. The addresses are: 0 direction, 1 idle pattern, 2 receive-only pattern, 3 transmit-only pattern, 4 duplex pattern.
- R3: Writes to addresses 5, 6 and 7 change no register and no pin. Reads of addresses 6 and 7 return 0.
- R4: The state register loads, at each rising edge, the state given by {tx_run, rx_run}: 00 gives idle, 01 gives receive only, 10 gives transmit only, 11 gives duplex.
- R5: The output pins show the pattern for the new state, masked by direction, after the first rising edge that samples a change of the activity flags. Before that edge they keep the previous pattern.
- R6: A direction bit of 1 makes that pin an output (output-enable 1). A direction bit of 0 gives output-enable 0 and an output value of 0 on that pin.
- R7: Pin bits 15:0 map to the `rxg_*` ports and bits 31:16 to the `txg_*` ports, for output, output-enable and input.
- R8: Address 5 reads {txg_in, rxg_in}, delayed by two flops. A new input level appears after the second rising edge following its change, and not after the first.
- R9: A pattern or direction write reaches the pins and the output-enables on the same edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| rx_run | input | 1 | Receive chain active |
| tx_run | input | 1 | Transmit chain active |
| rxg_in | input | 16 | Pin levels, receive-side group |
| txg_in | input | 16 | Pin levels, transmit-side group |
| rxg_out | output | 16 | Driven values, receive-side group |
| rxg_oe | output | 16 | Output-enables, receive-side group |
| txg_out | output | 16 | Driven values, transmit-side group |
| txg_oe | output | 16 | Output-enables, transmit-side group |

## Verification
All 16 ordered pairs of activity states are applied, and the pins are sampled both just before and just after the capturing edge. This shows that every decode value is right and that the latency is exactly one edge. The sweep is repeated under several direction masks: all-in, all-out, each half alone, and an interleaved mask. Each mask uses patterns that differ per state, so a swapped state, a missed mask bit or a swapped group shows up as a different word. A write to an unused address is followed by readback of all five registers and the pins. Input patterns are tracked across the two synchronizer edges to confirm the depth.

// File: rtl/atr_pkg.sv
package atr_pkg;

    localparam int unsigned NUM_MODES = 4;

    // Order matters: a state's value plus REG_BANK0 gives its pattern address.
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_RX     = 2'd1,
        MODE_TX     = 2'd2,
        MODE_DUPLEX = 2'd3
    } atr_mode_e;

    localparam int unsigned REG_DIR   = 0;
    localparam int unsigned REG_BANK0 = 1;
    localparam int unsigned REG_PINS  = REG_BANK0 + NUM_MODES;

endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] age_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          age_q <= '0;
                else if (age_q != 2) age_q <= age_q + 2'd1;
            end
            // R8: the readback equals the input from two edges earlier
            p_sync_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/atr_regfile.sv
module atr_regfile
    import atr_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [AW-1:0]                addr_i,
    input  logic [W-1:0]                 wdata_i,
    input  logic [W-1:0]                 pins_sync_i,
    output logic [W-1:0]                 rdata_o,
    output logic [W-1:0]                 dir_o,
    output logic [NUM_MODES-1:0][W-1:0]  bank_o
);

    logic [W-1:0]                dir_q;
    logic [NUM_MODES-1:0][W-1:0] bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 dir_q <= '0;
        else if (wr_i && addr_i == AW'(REG_DIR))    dir_q <= wdata_i;
    end

    generate
        for (genvar g = 0; g < NUM_MODES; g++) begin : g_bank
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                  bank_q[g] <= '0;
                else if (wr_i && addr_i == AW'(REG_BANK0 + g)) bank_q[g] <= wdata_i;
            end
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(REG_DIR))  rdata_o = dir_q;
        if (addr_i == AW'(REG_PINS)) rdata_o = pins_sync_i;
        for (int g = 0; g < NUM_MODES; g++) begin
            if (addr_i == AW'(REG_BANK0 + g)) rdata_o = bank_q[g];
        end
    end

    assign dir_o  = dir_q;
    assign bank_o = bank_q;

    // R2: a direction write lands on the following edge
    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == AW'(REG_DIR)) |=> (dir_q == $past(wdata_i)));

    // R3: writes above the pattern registers leave all storage unchanged
    p_high_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i >= AW'(REG_PINS)) |=> ($stable(dir_q) && $stable(bank_q)));

endmodule

// File: rtl/atr_mode_fsm.sv
module atr_mode_fsm
    import atr_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_run_i,
    input  logic                         tx_run_i,
    input  logic [W-1:0]                 dir_i,
    input  logic [NUM_MODES-1:0][W-1:0]  bank_i,
    output logic [W-1:0]                 pin_out_o,
    output logic [W-1:0]                 pin_oe_o
);

    atr_mode_e state_q, state_d;
    logic [W-1:0] sel_pat;
    logic seen_q;

    // Next-state: the transition is named by the state it enters
    always_comb begin
        unique case ({tx_run_i, rx_run_i})
            2'b00:   state_d = MODE_IDLE;    // enter-idle
            2'b01:   state_d = MODE_RX;      // enter-rx
            2'b10:   state_d = MODE_TX;      // enter-tx
            default: state_d = MODE_DUPLEX;  // enter-duplex
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_IDLE;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            MODE_IDLE:   sel_pat = bank_i[0];
            MODE_RX:     sel_pat = bank_i[1];
            MODE_TX:     sel_pat = bank_i[2];
            MODE_DUPLEX: sel_pat = bank_i[3];
            default:     sel_pat = '0;
        endcase
        pin_out_o = sel_pat & dir_i;
        pin_oe_o  = dir_i;
    end

    // R4: no activity sampled, so the state is idle
    p_idle_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(rx_run_i) && !$past(tx_run_i)) |-> (state_q == MODE_IDLE));

    // R4: both flags sampled, so the state is duplex
    p_duplex_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(rx_run_i) && $past(tx_run_i)) |-> (state_q == MODE_DUPLEX));

    // R5: transmit only sampled, so the pins carry the transmit pattern
    p_tx_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(tx_run_i) && !$past(rx_run_i) && $stable(bank_i) && $stable(dir_i))
        |-> (pin_out_o == ($past(bank_i[2]) & dir_i)));

endmodule

// File: rtl/atr_gpio_ctrl.sv
module atr_gpio_ctrl
    import atr_pkg::*;
#(
    parameter int unsigned PIN_W       = 32,
    parameter int unsigned AW          = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [AW-1:0]        cfg_addr,
    input  logic [PIN_W-1:0]     cfg_wdata,
    output logic [PIN_W-1:0]     cfg_rdata,
    input  logic                 rx_run,
    input  logic                 tx_run,
    input  logic [PIN_W/2-1:0]   rxg_in,
    input  logic [PIN_W/2-1:0]   txg_in,
    output logic [PIN_W/2-1:0]   rxg_out,
    output logic [PIN_W/2-1:0]   rxg_oe,
    output logic [PIN_W/2-1:0]   txg_out,
    output logic [PIN_W/2-1:0]   txg_oe
);

    localparam int unsigned GRP_W = PIN_W / 2;

    logic [PIN_W-1:0]                pins_raw, pins_sync, dir_w, pin_out, pin_oe;
    logic [NUM_MODES-1:0][PIN_W-1:0] bank_w;

    assign pins_raw = {txg_in, rxg_in};

    atr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_sync)
    );

    atr_regfile #(.W(PIN_W), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (cfg_wr),
        .addr_i      (cfg_addr),
        .wdata_i     (cfg_wdata),
        .pins_sync_i (pins_sync),
        .rdata_o     (cfg_rdata),
        .dir_o       (dir_w),
        .bank_o      (bank_w)
    );

    atr_mode_fsm #(.W(PIN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_run_i  (rx_run),
        .tx_run_i  (tx_run),
        .dir_i     (dir_w),
        .bank_i    (bank_w),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe)
    );

    // R7: group split
    assign rxg_out = pin_out[GRP_W-1:0];
    assign txg_out = pin_out[PIN_W-1:GRP_W];
    assign rxg_oe  = pin_oe[GRP_W-1:0];
    assign txg_oe  = pin_oe[PIN_W-1:GRP_W];

    // R6: a pin that is not enabled never carries a 1
    p_undriven_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/atr_gpio_ctrl_test.sv
module atr_gpio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rx_run = 1'b0, tx_run = 1'b0;
    logic [15:0] rxg_in = '0, txg_in = '0;
    logic [15:0] rxg_out, rxg_oe, txg_out, txg_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] m_dir;
    logic [31:0] m_bank [4];
    int          m_mode;

    always #5 clk = ~clk;

    atr_gpio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_run(rx_run),
        .tx_run(tx_run), .rxg_in(rxg_in), .txg_in(txg_in),
        .rxg_out(rxg_out), .rxg_oe(rxg_oe), .txg_out(txg_out), .txg_oe(txg_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic chk_pins(input string req);
        chk({req, " out"}, {txg_out, rxg_out}, m_bank[m_mode] & m_dir);
        chk({req, " oe"},  {txg_oe, rxg_oe},   m_dir);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 3'd0) m_dir = d;
        else if (a <= 3'd4) m_bank[a-1] = d;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    // R4 R5: apply a state, check latency and result
    task automatic go_mode(input int m);
        @(negedge clk);
        rx_run = m[0]; tx_run = m[1];
        #1 chk_pins("R5 before edge");
        @(negedge clk);
        m_mode = m;
        #1 chk_pins("R4 R5 after edge");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        m_dir = '0; m_mode = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 out during reset", {txg_out, rxg_out}, 32'h0);
        chk("R1 oe during reset",  {txg_oe, rxg_oe},   32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        for (int a = 0; a < 6; a++) rd_chk("R1 readback", 3'(a), 32'h0);
        chk_pins("R1 pins");

        // R2: write and read each register
        for (int a = 0; a < 5; a++) begin
            wr(3'(a), 32'h1357_9BDF ^ (32'h1111_1111 * (a + 1)));
        end
        for (int a = 0; a < 5; a++)
            rd_chk("R2 readback", 3'(a), (a == 0) ? m_dir : m_bank[a-1]);

        // R3: unused addresses
        wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
        for (int a = 0; a < 5; a++)
            rd_chk("R3 regs kept", 3'(a), (a == 0) ? m_dir : m_bank[a-1]);
        rd_chk("R3 addr6 zero", 3'd6, 32'h0);
        rd_chk("R3 addr7 zero", 3'd7, 32'h0);
        chk_pins("R3 pins kept");

        // Sweep direction masks x all ordered state pairs
        for (int d = 0; d < 5; d++) begin
            logic [31:0] dm;
            case (d)
                0: dm = 32'h0000_0000;
                1: dm = 32'hFFFF_FFFF;
                2: dm = 32'h0000_FFFF;
                3: dm = 32'hFFFF_0000;
                default: dm = 32'hA5C3_5A3C;
            endcase
            for (int b = 0; b < 4; b++) begin
                logic [31:0] pat;
                pat = (32'h0F1E_2D3C * (b + 1 + d)) ^ (32'h8000_0001 << b);
                wr(3'(b + 1), pat);
                // R9: pattern write visible on same edge that stores it
                chk_pins("R9 pattern write");
            end
            wr(3'd0, dm);
            chk_pins("R9 R6 dir write");
            chk("R7 rx group oe", {16'h0, rxg_oe}, {16'h0, dm[15:0]});
            chk("R7 tx group out", {16'h0, txg_out}, {16'h0, m_bank[m_mode][31:16] & dm[31:16]});
            for (int from = 0; from < 4; from++) begin
                for (int to = 0; to < 4; to++) begin
                    go_mode(from);
                    go_mode(to);
                end
            end
        end

        // R8: two-flop input synchronizer
        @(negedge clk);
        txg_in = 16'hC3A5; rxg_in = 16'h0F96;
        rd_chk("R8 before edge", 3'd5, 32'h0);
        @(negedge clk);
        rd_chk("R8 after one edge", 3'd5, 32'h0);
        @(negedge clk);
        rd_chk("R8 after two edges", 3'd5, 32'hC3A5_0F96);
        @(negedge clk);
        txg_in = 16'h1234; rxg_in = 16'hFEDC;
        @(negedge clk);
        rd_chk("R8 second pattern hold", 3'd5, 32'hC3A5_0F96);
        @(negedge clk);
        rd_chk("R8 second pattern", 3'd5, 32'h1234_FEDC);

        finish_run();
    end

endmodule